// File: doc/BRIEF.md
# Cascadable serial configuration bitstream sequencer

This block holds a configuration image as an array of bits and sends it, one bit per serial clock, to a programmable logic target. It has a bit address counter, an active-low output-enable/reset input and an active-low chip select. The serial line is shown as a data bit and a matching output enable, so that several of these blocks can share one target data input. The image is written through a simple per-bit load port, which is there for test.

Each block decides its role in the chain when its reset input is released. If chip select is low at that moment, the block is the chain master. It makes the serial clock by dividing the system clock and drives that clock to itself and to the blocks downstream. When the target signals done, by pulling the master's chip select high, the master sends a fixed run of trailing clocks and then parks the clock low. If chip select is high at release, the block follows an external serial clock. A downstream block is enabled through its chip select by the cascade output of the block before it. The master raises an error if done comes before its own image has been fully sent, or if done has not come within a set number of clocks after the last bit.

Top module: `cfg_stream_seq`

## Requirements
- R1: While oe_rst_n is low, the bit counter is held at zero. data_oe is 0, casc_n is 1, err is 0 and dclk_out is 0. This holds whatever the level of cs_n.
- R2: The role is taken from cs_n during the last system clock in which oe_rst_n is low. cs_n low makes the block master, with dclk_oe=1, and it runs from its own clock. cs_n high makes it downstream, with dclk_oe=0 and dclk_out=0, and it counts rising edges of dclk_in.
- R3: While cs_n is high the counter does not move and data_oe is 0, even when serial clock edges arrive. When cs_n goes low, data_oe goes to 1 and data_out shows the bit at the current address.
- R4: Bits leave in address order 0 to DEPTH-1. Each rising serial clock edge moves the counter on by exactly one. The bit presented at a rising edge is the bit at the address held before that edge.
- R5: After DEPTH rising edges, casc_n is 0 and data_oe is 0. Further edges change neither the counter nor these outputs until the next reset.
- R6: As master, dclk_out has a period of CLK_DIV system clocks and is high for CLK_DIV/2 of them. It keeps running after the image is exhausted, so it can clock the downstream blocks.
- R7: If cs_n goes high after the master's last bit, dclk_out gives exactly TAIL_CLKS further rising edges and then stays low. err stays 0.
- R8: If cs_n goes high on the master before all DEPTH bits are sent, err goes to 1, the serial clock stops, and err holds until oe_rst_n goes low.
- R9: If the master sees DONE_TIMEOUT rising edges after its last bit with cs_n still low, err goes to 1 and the serial clock stops.
- R10: After the power-up reset rst_n, the block is downstream with the counter at zero, casc_n=1, data_oe=0 and err=0.
- R11: A write with ld_we=1 stores ld_bit at address ld_addr. That bit is the one later sent at that address position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low |
| oe_rst_n | input | 1 | Output enable when high, sequence reset when low |
| cs_n | input | 1 | Chip select, active low; target done on the master |
| dclk_in | input | 1 | Serial clock from upstream, used when downstream |
| dclk_out | output | 1 | Serial clock generated as master |
| dclk_oe | output | 1 | High when this block drives the serial clock |
| data_out | output | 1 | Serial bit |
| data_oe | output | 1 | Drive enable for data_out |
| casc_n | output | 1 | Low once the whole image has been sent |
| err | output | 1 | Configuration error flag (master only) |
| ld_we | input | 1 | Image load strobe |
| ld_addr | input | $clog2(DEPTH) | Image load bit address |
| ld_bit | input | 1 | Image load bit value |

## Verification
A rising edge of dclk_out appears one system clock after the divider wraps. The data bit stays valid during the negative clock phase that follows, because the counter takes the detected edge only at the next system clock edge. The bench therefore samples data_out at that first negative edge. A dclk_in edge driven at a negative edge is taken at the following positive edge, so the bench allows three clocks before checking the next bit. err and casc_n are registered one clock after the deciding edge, and the bench checks them two or more clocks later. Clock counts (period, trailing run, timeout run) are found by counting dclk_out rises until none has come for twenty clocks.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_TAIL = 2'd1,
    PH_IDLE = 2'd2
  } phase_e;

  // width needed to hold values 0..n
  function automatic int span_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // last count of the high half of a divided clock
  function automatic int high_last(input int div);
    return div / 2 - 1;
  endfunction

endpackage

// File: rtl/cfg_dclk_gen.sv
module cfg_dclk_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic dclk
);
  import cfg_stream_pkg::*;

  localparam int DW = $clog2(DIV);
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);
  localparam logic [DW-1:0] HLAST = DW'(high_last(DIV));

  logic [DW-1:0] cnt;

  function automatic logic [DW-1:0] step_cnt(input logic [DW-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      dclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      dclk <= 1'b0;
    end else begin
      cnt <= step_cnt(cnt);
      if (cnt == LAST)       dclk <= 1'b1;
      else if (cnt == HLAST) dclk <= 1'b0;
    end
  end

  assert_rise_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk) |-> (cnt == '0));
  assert_fall_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dclk) && $past(run)) |-> (cnt == HLAST + 1'b1));
endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     ld_we,
  input  logic [$clog2(DEPTH)-1:0] ld_addr,
  input  logic                     ld_bit,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic                     rd_bit
);
  logic [DEPTH-1:0] bits;

  always_ff @(posedge clk) begin
    if (ld_we) bits[ld_addr] <= ld_bit;
  end

  assign rd_bit = bits[rd_addr];
endmodule

// File: rtl/cfg_bit_ctr.sv
module cfg_bit_ctr #(
  parameter int DEPTH = 32
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      clr,
  input  logic                                      edge_hit,
  input  logic                                      sel,
  output logic [cfg_stream_pkg::span_bits(DEPTH)-1:0] addr,
  output logic                                      full
);
  import cfg_stream_pkg::*;

  localparam int CW = span_bits(DEPTH);
  localparam logic [CW-1:0] END = CW'(DEPTH);

  function automatic logic reached_end(input logic [CW-1:0] a);
    return a == END;
  endfunction

  assign full = reached_end(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      addr <= '0;
    else if (clr)                    addr <= '0;
    else if (edge_hit && sel && !full) addr <= addr + 1'b1;
  end

  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != $past(addr)) |-> (addr == $past(addr) + 1'b1 || addr == '0));
  assert_frozen_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(full) && !$past(clr)) |-> $stable(addr));
  assert_hold_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sel) && !$past(clr)) |-> $stable(addr));
endmodule

// File: rtl/cfg_stream_seq.sv
module cfg_stream_seq #(
  parameter int DEPTH        = 32,
  parameter int CLK_DIV      = 4,
  parameter int TAIL_CLKS    = 16,
  parameter int DONE_TIMEOUT = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     oe_rst_n,
  input  logic                     cs_n,
  input  logic                     dclk_in,
  output logic                     dclk_out,
  output logic                     dclk_oe,
  output logic                     data_out,
  output logic                     data_oe,
  output logic                     casc_n,
  output logic                     err,
  input  logic                     ld_we,
  input  logic [$clog2(DEPTH)-1:0] ld_addr,
  input  logic                     ld_bit
);
  import cfg_stream_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int CW = span_bits(DEPTH);
  localparam int TW = span_bits(TAIL_CLKS);
  localparam int WW = span_bits(DONE_TIMEOUT);
  localparam logic [TW-1:0] TAIL_END = TW'(TAIL_CLKS);
  localparam logic [WW-1:0] WAIT_LAST = WW'(DONE_TIMEOUT - 1);

  logic          is_master;
  phase_e        phase;
  logic [TW-1:0] tail_cnt;
  logic [WW-1:0] wait_cnt;
  logic          dclk_q;
  logic          gen_dclk;
  logic          gen_run;
  logic          dclk_src;
  logic          dclk_rise;
  logic [CW-1:0] bit_addr;
  logic          img_full;
  logic          cur_bit;

  assign gen_run   = is_master && oe_rst_n && (phase != PH_IDLE);
  assign dclk_src  = is_master ? gen_dclk : dclk_in;
  assign dclk_rise = dclk_src && !dclk_q;

  cfg_dclk_gen #(.DIV(CLK_DIV)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(gen_run), .dclk(gen_dclk)
  );

  cfg_bit_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(!oe_rst_n), .edge_hit(dclk_rise),
    .sel(!cs_n), .addr(bit_addr), .full(img_full)
  );

  cfg_bit_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .ld_we(ld_we), .ld_addr(ld_addr), .ld_bit(ld_bit),
    .rd_addr(bit_addr[AW-1:0]), .rd_bit(cur_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_master <= 1'b0;
      phase     <= PH_RUN;
      tail_cnt  <= '0;
      wait_cnt  <= '0;
      err       <= 1'b0;
      dclk_q    <= 1'b0;
    end else begin
      dclk_q <= dclk_src;
      if (!oe_rst_n) begin
        is_master <= !cs_n;
        phase     <= PH_RUN;
        tail_cnt  <= '0;
        wait_cnt  <= '0;
        err       <= 1'b0;
      end else if (is_master) begin
        unique case (phase)
          PH_RUN: begin
            if (cs_n && !img_full) begin
              err   <= 1'b1;
              phase <= PH_IDLE;
            end else if (cs_n) begin
              phase <= PH_TAIL;
            end else if (img_full && dclk_rise) begin
              wait_cnt <= wait_cnt + 1'b1;
              if (wait_cnt == WAIT_LAST) begin
                err   <= 1'b1;
                phase <= PH_IDLE;
              end
            end
          end
          PH_TAIL: begin
            if (dclk_rise)                                tail_cnt <= tail_cnt + 1'b1;
            else if (tail_cnt == TAIL_END && !gen_dclk)   phase    <= PH_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign dclk_out = gen_dclk;
  assign dclk_oe  = is_master;
  assign data_oe  = oe_rst_n && !cs_n && !img_full;
  assign data_out = data_oe && cur_bit;
  assign casc_n   = !img_full;

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(oe_rst_n) |-> (bit_addr == '0 && !err && !gen_dclk));
  assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && $past(phase == PH_IDLE)) |-> !gen_dclk);
  assert_tail_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tail_cnt <= TAIL_END);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err) && $past(oe_rst_n)) |-> err);
  assert_follower_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> (!gen_dclk && !err));
endmodule

// File: tb/tb_cfg_stream_seq.sv
module tb_cfg_stream_seq;
  localparam int DEPTH = 16;
  localparam int DIV   = 4;
  localparam int TAIL  = 16;
  localparam int TOUT  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe_rst_n = 1'b1;
  logic cs_n = 1'b1;
  logic dclk_in = 1'b0;
  logic ld_we = 1'b0;
  logic [3:0] ld_addr = '0;
  logic ld_bit = 1'b0;
  logic dclk_o, dclk_oe, data_o, data_oe, casc_n, err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_stream_seq #(.DEPTH(DEPTH), .CLK_DIV(DIV), .TAIL_CLKS(TAIL), .DONE_TIMEOUT(TOUT)) dut (
    .clk(clk), .rst_n(rst_n), .oe_rst_n(oe_rst_n), .cs_n(cs_n), .dclk_in(dclk_in),
    .dclk_out(dclk_o), .dclk_oe(dclk_oe), .data_out(data_o), .data_oe(data_oe),
    .casc_n(casc_n), .err(err), .ld_we(ld_we), .ld_addr(ld_addr), .ld_bit(ld_bit)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [DEPTH-1:0] p);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = 4'(i); ld_bit = p[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic next_rise(input int lim, output bit got, output int gap);
    logic p;
    got = 0; gap = 0; p = dclk_o;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      gap++;
      if (dclk_o && !p) begin got = 1; return; end
      p = dclk_o;
    end
  endtask

  task automatic count_rises(output int n);
    bit g; int gp;
    n = 0;
    for (int i = 0; i < 400; i++) begin
      next_rise(20, g, gp);
      if (!g) return;
      n++;
    end
  endtask

  task automatic pulse_in();
    dclk_in = 1'b1; ticks(3);
    dclk_in = 1'b0; ticks(3);
  endtask

  task automatic start_master();
    @(negedge clk);
    cs_n = 1'b0; oe_rst_n = 1'b0;
    ticks(3);
    oe_rst_n = 1'b1;
  endtask

  task automatic stream_all(input logic [DEPTH-1:0] p, input bit check_bits);
    bit g; int gp;
    for (int k = 0; k < DEPTH; k++) begin
      next_rise(20, g, gp);
      if (check_bits) begin
        chk("R6 master rise present", g, 1);
        chk("R4 R11 bit order", data_o, p[k]);
        chk("R3 data driven", data_oe, 1);
        if (k > 0) chk("R6 period", gp, DIV);
      end
    end
  endtask

  initial begin
    logic [DEPTH-1:0] pa, pb;
    bit g; int gp, n;
    pa = 16'hB4E1;
    pb = 16'h3A9C;
    ticks(3);
    rst_n = 1'b1;
    ticks(2);
    // R10 power-up state
    chk("R10 casc_n", casc_n, 1);
    chk("R10 data_oe", data_oe, 0);
    chk("R10 err", err, 0);
    chk("R10 dclk_oe", dclk_oe, 0);

    load(pa);

    // R1 reset with chip select low, master chosen
    @(negedge clk); cs_n = 1'b0; oe_rst_n = 1'b0;
    ticks(3);
    chk("R1 data_oe", data_oe, 0);
    chk("R1 casc_n", casc_n, 1);
    chk("R1 dclk_out", dclk_o, 0);
    chk("R1 err", err, 0);
    chk("R2 master dclk_oe", dclk_oe, 1);
    oe_rst_n = 1'b1;
    stream_all(pa, 1);
    ticks(2);
    chk("R5 casc_n low", casc_n, 0);
    chk("R5 data_oe off", data_oe, 0);
    // R6 clock continues after the image
    next_rise(20, g, gp); chk("R6 run on 1", g, 1);
    next_rise(20, g, gp); chk("R6 run on 2", g, 1);
    cs_n = 1'b1;
    count_rises(n);
    chk("R7 trailing rises", n, TAIL);
    chk("R7 err clear", err, 0);
    chk("R7 dclk parked", dclk_o, 0);

    // R9 done never arrives
    start_master();
    stream_all(pa, 0);
    count_rises(n);
    chk("R9 rises before error", n, TOUT);
    chk("R9 err set", err, 1);
    chk("R9 dclk parked", dclk_o, 0);

    // R8 early done
    start_master();
    for (int k = 0; k < 5; k++) next_rise(20, g, gp);
    cs_n = 1'b1;
    ticks(3);
    chk("R8 err set", err, 1);
    chk("R8 data_oe", data_oe, 0);
    chk("R8 casc_n", casc_n, 1);
    count_rises(n);
    chk("R8 clock stopped", n, 0);
    chk("R8 err held", err, 1);

    // R1 mid-stream reset clears error and restarts at bit 0
    start_master();
    ticks(1);
    chk("R1 err cleared", err, 0);
    for (int k = 0; k < 3; k++) next_rise(20, g, gp);
    oe_rst_n = 1'b0;
    ticks(2);
    chk("R1 mid data_oe", data_oe, 0);
    chk("R1 mid dclk", dclk_o, 0);
    oe_rst_n = 1'b1;
    next_rise(20, g, gp);
    chk("R1 restart bit0", data_o, pa[0]);

    // R2 downstream
    @(negedge clk); oe_rst_n = 1'b0; cs_n = 1'b1;
    load(pb);
    ticks(2);
    oe_rst_n = 1'b1;
    ticks(2);
    chk("R2 follower dclk_oe", dclk_oe, 0);
    chk("R3 deselected data_oe", data_oe, 0);
    for (int k = 0; k < 3; k++) pulse_in();
    chk("R3 deselected casc_n", casc_n, 1);
    cs_n = 1'b0;
    ticks(1);
    chk("R3 selected data_oe", data_oe, 1);
    chk("R3 held at bit0", data_o, pb[0]);
    for (int k = 1; k < DEPTH; k++) begin
      pulse_in();
      chk("R4 R11 follower bit", data_o, pb[k]);
    end
    pulse_in();
    chk("R5 follower casc_n", casc_n, 0);
    chk("R5 follower data_oe", data_oe, 0);
    pulse_in();
    pulse_in();
    chk("R5 casc held", casc_n, 0);
    chk("R2 follower err", err, 0);
    chk("R2 follower dclk_out", dclk_o, 0);

    // R3 follower: deselect mid-stream does not move counter
    @(negedge clk); oe_rst_n = 1'b0; cs_n = 1'b1;
    ticks(2); oe_rst_n = 1'b1; ticks(1);
    cs_n = 1'b0; pulse_in(); pulse_in();
    cs_n = 1'b1; pulse_in(); pulse_in();
    cs_n = 1'b0; ticks(1);
    chk("R3 resume at bit2", data_o, pb[2]);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule